// File: doc/BRIEF.md
# Mask-Clear Event Status Register

This block watches 32 per-function interrupt mask bits and records, in one sticky 32-bit status word, every function whose mask has just been released (a 1-to-0 change), no matter which agent performed the change. Recording happens only while a global mask-change event enable is high. Firmware reads the word through a small valid/write/address/data port at a fixed byte offset and acknowledges events by writing ones to the bits it has handled.

Any recorded event that is not masked by a companion per-bit interrupt mask drives a single level-sensitive local interrupt line. The line stays high until firmware has cleared every unmasked event bit. The previous value of each function mask is held in a flop, so a release is seen as a single-cycle event. That flop starts at 0, so a mask already high when reset ends does not produce an event.

Top module: `mcs_event_status`

## Requirements
- R1: When `fn_mask_i[n]` was 1 in the previous cycle and is 0 now, and `evt_en_i` is 1 in this cycle, status bit n reads 1 from the next cycle on. Bit n stands for function 28+n: bit 0 is function 28 and bit 31 is function 59.
- R2: When `evt_en_i` is 0 in the cycle a release is seen, no status bit is set. Raising the enable later does not set the bit for that past release.
- R3: A write hit with data bit n = 1 clears status bit n in the next cycle. A data bit of 0 leaves the status bit unchanged.
- R4: If a release on bit n and a write-one clear of bit n fall in the same cycle, the bit ends up 1.
- R5: A mask bit that rises or stays steady never changes the status word. This includes a mask that is already 1 when reset is released.
- R6: `local_irq_o` is a flop that loads the OR of (status AND NOT `irq_mask_i`), where an `irq_mask_i` bit of 1 means masked. The line therefore follows the status word one cycle later.
- R7: Once asserted, `local_irq_o` stays 1 until every unmasked set status bit has been cleared by a write.
- R8: While reset is asserted, and in the first cycle after it, the status word is 0 and `local_irq_o` is 0.
- R9: The port responds only to byte address 0xD28. A write to another address changes nothing. A read of another address returns 0.
- R10: A read hit (`reg_valid_i`=1, `reg_we_i`=0) returns the current status word on `reg_rdata_o` in the same cycle and does not change the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_mask_i | input | 32 | Per-function mask bits being watched |
| evt_en_i | input | 1 | Global enable for recording release events |
| irq_mask_i | input | 32 | Per-bit interrupt mask, 1 = masked |
| reg_valid_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte address |
| reg_wdata_i | input | 32 | Write data, ones clear status bits |
| reg_rdata_o | output | 32 | Read data, status on a read hit, else 0 |
| local_irq_o | output | 1 | Registered level interrupt |

## Verification
The bench targets a release and a clear that land on the same bit in the same cycle. A design that lets the clear win would lose the event and read 0. It also checks a release seen while the enable is low and then a late rise of the enable. A design that latched the event, or that gated the result rather than the edge, would set the bit late. It drives a mask that is already high when reset ends. A previous-value flop with the wrong reset value would report a false event there. Finally, it tests writes to a neighbouring address and an all-zero write, which a loose decoder or a plain write would turn into lost status, and it checks that an interrupt masked while its event is pending stays low and then rises one cycle after the mask is removed.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int unsigned MCS_NUM_FN = 32;
  localparam int unsigned MCS_ADDR_W = 12;
  localparam logic [MCS_ADDR_W-1:0] MCS_REG_OFS = 12'hD28;

  typedef logic [MCS_NUM_FN-1:0] fn_vec_t;

  // A release is the previous value high and the present value low
  function automatic fn_vec_t release_events(fn_vec_t prev, fn_vec_t cur);
    return prev & ~cur;
  endfunction

  function automatic fn_vec_t gate_events(fn_vec_t ev, logic en);
    return en ? ev : '0;
  endfunction

  // Clear first, then set, so a simultaneous event survives
  function automatic fn_vec_t w1c_update(fn_vec_t st, fn_vec_t set, fn_vec_t clr);
    return (st & ~clr) | set;
  endfunction

  function automatic logic irq_pending(fn_vec_t st, fn_vec_t msk);
    return |(st & ~msk);
  endfunction
endpackage

// File: rtl/mcs_fall_detect.sv
module mcs_fall_detect
  import mcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fn_vec_t mask_i,
  output fn_vec_t prev_o,
  output fn_vec_t fall_o
);
  fn_vec_t prev_q;

  for (genvar g = 0; g < MCS_NUM_FN; g++) begin : g_prev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= mask_i[g];
    end
  end

  assign prev_o = prev_q;
  assign fall_o = release_events(prev_q, mask_i);
endmodule

// File: rtl/mcs_status_bank.sv
module mcs_status_bank
  import mcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fn_vec_t set_i,
  input  fn_vec_t clr_i,
  output fn_vec_t status_o
);
  fn_vec_t status_q;
  fn_vec_t status_d;

  assign status_d = w1c_update(status_q, set_i, clr_i);

  for (genvar g = 0; g < MCS_NUM_FN; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[g] <= 1'b0;
      else        status_q[g] <= status_d[g];
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/mcs_irq_agg.sv
module mcs_irq_agg
  import mcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fn_vec_t status_i,
  input  fn_vec_t mask_i,
  output logic    irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_pending(status_i, mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mcs_event_status.sv
module mcs_event_status
  import mcs_pkg::*;
#(
  parameter int unsigned ADDR_W = MCS_ADDR_W,
  parameter logic [ADDR_W-1:0] REG_OFS = MCS_REG_OFS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MCS_NUM_FN-1:0] fn_mask_i,
  input  logic                  evt_en_i,
  input  logic [MCS_NUM_FN-1:0] irq_mask_i,
  input  logic                  reg_valid_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [MCS_NUM_FN-1:0] reg_wdata_i,
  output logic [MCS_NUM_FN-1:0] reg_rdata_o,
  output logic                  local_irq_o
);
  // Named internal events, observed by the bound checker
  fn_vec_t prev_vec;
  fn_vec_t fall_raw;
  fn_vec_t set_vec;
  fn_vec_t clr_vec;
  fn_vec_t status_q;
  logic    addr_hit;
  logic    wr_hit;
  logic    rd_hit;

  assign addr_hit = reg_valid_i && (reg_addr_i == REG_OFS);
  assign wr_hit   = addr_hit && reg_we_i;
  assign rd_hit   = addr_hit && !reg_we_i;

  mcs_fall_detect u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .mask_i (fn_mask_i),
    .prev_o (prev_vec),
    .fall_o (fall_raw)
  );

  assign set_vec = gate_events(fall_raw, evt_en_i);
  assign clr_vec = wr_hit ? reg_wdata_i : '0;

  mcs_status_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status_q)
  );

  mcs_irq_agg u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_q),
    .mask_i   (irq_mask_i),
    .irq_o    (local_irq_o)
  );

  assign reg_rdata_o = rd_hit ? status_q : '0;
endmodule

// File: rtl/mcs_event_status_chk.sv
module mcs_event_status_chk
  import mcs_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    evt_en_i,
  input fn_vec_t fall_raw,
  input fn_vec_t set_vec,
  input fn_vec_t clr_vec,
  input fn_vec_t status_q,
  input fn_vec_t irq_mask_i,
  input logic    local_irq_o
);
  // R1 and R4: a gated release is visible next cycle even under a clear
  p_set_on_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R2: nothing new appears while recording is disabled
  p_no_set_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en_i |=> ((status_q & ~$past(status_q)) == '0));

  // R3: cleared bits without a competing event drop
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

  // R4: a clear of a bit that sees a release in the same cycle leaves it set
  p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & set_vec) != '0) |=> ((status_q & $past(clr_vec & set_vec)) != '0));

  // R5: any newly set bit had a release behind it
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status_q & ~$past(status_q) & ~$past(fall_raw)) == '0));

  // R6: the line follows unmasked status one cycle later
  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (local_irq_o == (|($past(status_q) & ~$past(irq_mask_i)))));

  // R8: reset holds everything low
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0 && !local_irq_o));
endmodule

bind mcs_event_status mcs_event_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_en_i    (evt_en_i),
  .fall_raw    (fall_raw),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .status_q    (status_q),
  .irq_mask_i  (irq_mask_i),
  .local_irq_o (local_irq_o)
);

// File: tb/mcs_event_status_tb.sv
module mcs_event_status_tb_top;
  localparam logic [11:0] OFS  = 12'hD28;
  localparam logic [11:0] MISS = 12'hD2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fn_mask = '0;
  logic        evt_en = 1'b0;
  logic [31:0] irq_mask = '1;
  logic        reg_valid = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        local_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench reference state
  logic [31:0] prev_m = '0;
  logic [31:0] stat_m = '0;
  logic        irq_m  = 1'b0;

  always #2 clk = ~clk;

  mcs_event_status dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fn_mask_i   (fn_mask),
    .evt_en_i    (evt_en),
    .irq_mask_i  (irq_mask),
    .reg_valid_i (reg_valid),
    .reg_we_i    (reg_we),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .local_irq_o (local_irq)
  );

  function automatic logic [31:0] ref_next(logic [31:0] st, logic [31:0] pv,
      logic [31:0] cur, logic en, logic [31:0] clr);
    logic [31:0] ev;
    ev = en ? (pv & ~cur) : 32'h0;
    return (st & ~clr) | ev;
  endfunction

  function automatic logic ref_irq(logic [31:0] st, logic [31:0] msk);
    return (st & ~msk) != 32'h0;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle, starting and ending at a falling edge
  task automatic step(logic [31:0] m, logic en, logic [31:0] im,
      logic v, logic we, logic [11:0] a, logic [31:0] wd, string tag);
    logic [31:0] clr;
    fn_mask = m; evt_en = en; irq_mask = im;
    reg_valid = v; reg_we = we; reg_addr = a; reg_wdata = wd;
    #1;
    if (v && !we) check(reg_rdata, (a == OFS) ? stat_m : 32'h0, {tag, " R10 read"});
    clr = (v && we && a == OFS) ? wd : 32'h0;
    irq_m  = ref_irq(stat_m, im);
    stat_m = ref_next(stat_m, prev_m, m, en, clr);
    prev_m = m;
    @(negedge clk);
    reg_valid = 1'b0;
    check({31'h0, local_irq}, {31'h0, irq_m}, "R6 irq line");
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(fn_mask, evt_en, irq_mask, 0, 0, OFS, 0, "idle");
  endtask

  task automatic rd(logic [31:0] exp, string tag);
    check(stat_m, exp, {tag, " expectation"});
    step(fn_mask, evt_en, irq_mask, 1, 0, OFS, 0, tag);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    step(fn_mask, evt_en, irq_mask, 1, 1, a, d, "write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] m;
    void'($urandom(32'h5EED_0D28));
    // R5: mask high across reset release must not look like a release
    fn_mask = '1; evt_en = 1'b1;
    repeat (3) @(negedge clk);
    check(reg_rdata, 32'h0, "R8 rdata in reset");
    check({31'h0, local_irq}, 32'h0, "R8 irq in reset");
    rst_n = 1'b1;
    step('1, 1, '1, 0, 0, OFS, 0, "R5 post reset");
    rd(32'h0, "R8 status after reset");
    rd(32'h0, "R5 no event from reset");

    // R1: release on bit 0 (function 28) and bit 31 (function 59), masked line
    step(32'h7FFF_FFFE, 1, '1, 0, 0, OFS, 0, "R1 release");
    rd(32'h8000_0001, "R1 status set");
    check({31'h0, local_irq}, 32'h0, "R6 masked line low");
    // R6: unmask bit 31, line rises one cycle after
    step(fn_mask, 1, 32'h7FFF_FFFF, 0, 0, OFS, 0, "R6 unmask");
    check({31'h0, local_irq}, 32'h1, "R6 line high");
    idle(4);
    check({31'h0, local_irq}, 32'h1, "R7 line held");
    // R3: zero write changes nothing, one clears
    wr(OFS, 32'h0);
    rd(32'h8000_0001, "R3 zero write");
    wr(OFS, 32'h8000_0000);
    rd(32'h0000_0001, "R3 bit 31 cleared");
    check({31'h0, local_irq}, 32'h0, "R7 line released");
    // R9: neighbouring address neither clears nor reads
    wr(MISS, '1);
    rd(32'h0000_0001, "R9 miss write");
    step(fn_mask, 1, fn_mask, 1, 0, MISS, 0, "R9 miss read");
    // R10: repeated reads keep the value
    rd(32'h0000_0001, "R10 first read");
    rd(32'h0000_0001, "R10 second read");
    // R2: release with enable low, then enable rises while mask stays low
    step(32'h7FFF_FFDE, 0, '1, 0, 0, OFS, 0, "R2 disabled release");
    step(32'h7FFF_FFDE, 1, '1, 0, 0, OFS, 0, "R2 late enable");
    rd(32'h0000_0001, "R2 no late set");
    // R5: rising masks change nothing
    step('1, 1, '1, 0, 0, OFS, 0, "R5 rise");
    rd(32'h0000_0001, "R5 rise ignored");
    // R4: clear bit 0 and release bit 4 together, plus clear bit 4
    wr(OFS, 32'h0000_0001);
    step(32'hFFFF_FFEF, 1, '1, 1, 1, OFS, 32'h0000_0010, "R4 race");
    rd(32'h0000_0010, "R4 set wins");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      m  = fn_mask ^ ($urandom & $urandom & $urandom);
      op = $urandom % 6;
      case (op)
        0: step(m, ($urandom % 4) != 0, irq_mask, 1, 0, OFS, 0, "R1 random");
        1: step(m, ($urandom % 4) != 0, irq_mask, 1, 1, OFS, $urandom & $urandom, "R3 random");
        2: step(m, ($urandom % 4) != 0, irq_mask, 1, 1, MISS, $urandom, "R9 random");
        3: step(m, ($urandom % 4) != 0, $urandom | $urandom, 0, 0, OFS, 0, "R6 random");
        default: step(m, ($urandom % 4) != 0, irq_mask, 0, 0, OFS, 0, "R5 random");
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule